// File: doc/BRIEF.md
# Two-Pass Sparse Extremum Compactor

The compactor turns a sparse two-dimensional array of 32-bit extremum code words into a dense list of feature records. The array sits in a memory outside the block. Each word describes one 2×2 cell of a detector output. It holds a sub-cell offset in x and y, an eight-bit mask with one bit per scale, and an octave number. The block emits one record for every set mask bit. Each record carries the position in full-resolution pixels, the scale and the octave.

Work runs in three phases. The counting walk reads the array one column at a time and adds each word's mask population count to that column's counter. A single prefix step then turns the column counters into exclusive start indices and latches the grand total. The scatter walk reads the array again in the same order. Each counter is preset to its start index, and each set mask bit is written to the address the counter holds, after which the counter steps. Records past the output capacity are dropped and raise an overflow flag. The reported count is always the true total.

Top module: `sxc_compactor`

## Requirements
- R1: After reset, busy, done, rd_en, wr_en and overflow are 0 and feat_count is 0.
- R2: Word fields: bit 0 is the x offset, bit 8 is the y offset, bits 23:16 are the mask (bit 16+k set means an extremum at scale k), and bits 31:24 are the octave. The word for (row, col) is at address row·COLS + col.
- R3: feat_count at done equals the sum over all words of the number of set mask bits.
- R4: Records are indexed from 0 with no gaps. Columns are taken in ascending order, rows within a column in ascending order, and scales within a word in ascending order.
- R5: A record holds x = (2·col + xoff) << octave and y = (2·row + yoff) << octave, truncated to COORD_W bits, together with the scale index and the octave.
- R6: The records of one word are written in consecutive cycles to consecutive addresses.
- R7: A record whose index is CAP or more is not written. overflow at done is 1 exactly when the total exceeds CAP.
- R8: done is high for one cycle, 5·W + T + 1 cycles after the clock edge that samples start, where W = ROWS·COLS and T is the total count including dropped records.
- R9: A start pulse while busy has no effect. feat_count and overflow stay unchanged from done until the next accepted start.
- R10: An array with no mask bits set produces no writes, a count of 0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_en | output | 1 | Array read request |
| rd_addr | output | $clog2(ROWS·COLS) | Array word address |
| rd_data | input | 32 | Array word, valid one cycle after rd_en |
| wr_en | output | 1 | Record write strobe |
| wr_addr | output | $clog2(CAP) | Record index |
| wr_x | output | COORD_W | Full-resolution x |
| wr_y | output | COORD_W | Full-resolution y |
| wr_scale | output | 3 | Scale index |
| wr_octave | output | 8 | Octave |
| feat_count | output | $clog2(8·ROWS·COLS+1) | Total feature count |
| overflow | output | 1 | Total exceeded capacity |

## Verification
Each word costs two cycles in the counting walk. The prefix step costs one cycle. Each word then costs three cycles plus one per set bit in the scatter walk, so done is due a known number of edges after start. The bench counts edges from the start edge and samples 1 ns after each edge. It checks that done appears on exactly the predicted edge. Records are captured at the clock edge that commits each write. The count and overflow are read on the done cycle and again several cycles later.

// File: rtl/sxc_pkg.sv
`timescale 1ns/1ps
package sxc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CRD, ST_CACC, ST_PFX, ST_SRD, ST_SLAT, ST_SEMIT, ST_FIN
   } sxc_state_e;

   localparam int XO_BIT   = 0;
   localparam int YO_BIT   = 8;
   localparam int MASK_LSB = 16;
   localparam int OCT_LSB  = 24;

   function automatic logic [3:0] popcnt8(input logic [7:0] m);
      logic [3:0] n;
      n = '0;
      for (int i = 0; i < 8; i++) n = n + {3'b000, m[i]};
      return n;
   endfunction
endpackage

// File: rtl/sxc_colbank.sv
`timescale 1ns/1ps
module sxc_colbank #(
   parameter int COLS  = 4,
   parameter int CW    = 2,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [CW-1:0]    col,
   input  logic [CNT_W-1:0] add_val,
   input  logic             pfx_en,
   output logic [CNT_W-1:0] col_val,
   output logic [CNT_W-1:0] total
);
   logic [CNT_W-1:0] cnt [COLS];
   logic [CNT_W-1:0] run [COLS+1];

   assign run[0] = '0;
   for (genvar i = 0; i < COLS; i++) begin : g_scan
      assign run[i+1] = run[i] + cnt[i];
   end

   assign col_val = cnt[col];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         for (int i = 0; i < COLS; i++) cnt[i] <= '0;
         total <= '0;
      end else if (pfx_en) begin
         for (int i = 0; i < COLS; i++) cnt[i] <= run[i];
         total <= run[COLS];
      end else if (add_en) begin
         cnt[col] <= cnt[col] + add_val;
      end
   end
endmodule

// File: rtl/sxc_expand.sv
`timescale 1ns/1ps
module sxc_expand #(
   parameter int RW      = 2,
   parameter int CW      = 2,
   parameter int COORD_W = 16
) (
   input  logic [7:0]         mask,
   input  logic [CW-1:0]      col,
   input  logic [RW-1:0]      row,
   input  logic               xoff,
   input  logic               yoff,
   input  logic [7:0]         oct,
   output logic               has_bit,
   output logic [2:0]         scale,
   output logic [7:0]         mask_nx,
   output logic [COORD_W-1:0] x,
   output logic [COORD_W-1:0] y
);
   always_comb begin
      scale = 3'd0;
      for (int i = 7; i >= 0; i--) if (mask[i]) scale = 3'(i);
   end

   assign has_bit = |mask;
   assign mask_nx = mask & (mask - 8'd1);
   assign x = COORD_W'({col, xoff}) << oct;
   assign y = COORD_W'({row, yoff}) << oct;
endmodule

// File: rtl/sxc_compactor.sv
`timescale 1ns/1ps
module sxc_compactor
   import sxc_pkg::*;
#(
   parameter int ROWS    = 4,
   parameter int COLS    = 4,
   parameter int CAP     = 16,
   parameter int COORD_W = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   output logic                              busy,
   output logic                              done,
   output logic                              rd_en,
   output logic [$clog2(ROWS*COLS)-1:0]      rd_addr,
   input  logic [31:0]                       rd_data,
   output logic                              wr_en,
   output logic [$clog2(CAP)-1:0]            wr_addr,
   output logic [COORD_W-1:0]                wr_x,
   output logic [COORD_W-1:0]                wr_y,
   output logic [2:0]                        wr_scale,
   output logic [7:0]                        wr_octave,
   output logic [$clog2(ROWS*COLS*8+1)-1:0]  feat_count,
   output logic                              overflow
);
   localparam int RW     = $clog2(ROWS);
   localparam int CW     = $clog2(COLS);
   localparam int ADDR_W = $clog2(ROWS*COLS);
   localparam int OUT_AW = $clog2(CAP);
   localparam int CNT_W  = $clog2(ROWS*COLS*8+1);

   if (ROWS < 2 || COLS < 2) begin : g_bad_dims
      $error("sxc_compactor: ROWS and COLS must be at least 2");
   end
   if (CAP < 2) begin : g_bad_cap
      $error("sxc_compactor: CAP must be at least 2");
   end
   if (COORD_W < CW + 2 || COORD_W < RW + 2) begin : g_bad_coord
      $error("sxc_compactor: COORD_W too narrow for the array");
   end

   sxc_state_e       st, st_nx;
   logic [RW-1:0]    row_q;
   logic [CW-1:0]    col_q;
   logic [31:0]      word_q;
   logic [7:0]       mask_q;
   logic             ovf_q;

   logic             bank_clr, bank_add, bank_pfx;
   logic [CNT_W-1:0] bank_val, bank_inc, bank_total;
   logic             last_pos, pos_adv, fits;
   logic             has_bit;
   logic [2:0]       sc;
   logic [7:0]       mask_nx;
   logic [COORD_W-1:0] xf, yf;

   assign last_pos = (row_q == RW'(ROWS-1)) && (col_q == CW'(COLS-1));
   assign fits     = int'(bank_val) < CAP;

   always_comb begin
      st_nx    = st;
      bank_clr = 1'b0;
      bank_add = 1'b0;
      bank_pfx = 1'b0;
      bank_inc = '0;
      rd_en    = 1'b0;
      wr_en    = 1'b0;
      pos_adv  = 1'b0;
      done     = 1'b0;
      unique case (st)
         ST_IDLE:  if (start) begin st_nx = ST_CRD; bank_clr = 1'b1; end
         ST_CRD:   begin rd_en = 1'b1; st_nx = ST_CACC; end
         ST_CACC: begin
            bank_add = 1'b1;
            bank_inc = CNT_W'(popcnt8(rd_data[MASK_LSB +: 8]));
            pos_adv  = 1'b1;
            st_nx    = last_pos ? ST_PFX : ST_CRD;
         end
         ST_PFX:   begin bank_pfx = 1'b1; st_nx = ST_SRD; end
         ST_SRD:   begin rd_en = 1'b1; st_nx = ST_SLAT; end
         ST_SLAT:  st_nx = ST_SEMIT;
         ST_SEMIT: begin
            if (has_bit) begin
               bank_add = 1'b1;
               bank_inc = CNT_W'(1);
               wr_en    = fits;
            end else begin
               pos_adv = 1'b1;
               st_nx   = last_pos ? ST_FIN : ST_SRD;
            end
         end
         ST_FIN:   begin done = 1'b1; st_nx = ST_IDLE; end
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         row_q  <= '0;
         col_q  <= '0;
         word_q <= '0;
         mask_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == ST_IDLE && start) begin
            row_q <= '0;
            col_q <= '0;
            ovf_q <= 1'b0;
         end
         if (pos_adv) begin
            if (last_pos) begin
               row_q <= '0;
               col_q <= '0;
            end else if (row_q == RW'(ROWS-1)) begin
               row_q <= '0;
               col_q <= col_q + CW'(1);
            end else begin
               row_q <= row_q + RW'(1);
            end
         end
         if (st == ST_SLAT) begin
            word_q <= rd_data;
            mask_q <= rd_data[MASK_LSB +: 8];
         end
         if (st == ST_SEMIT && has_bit) begin
            mask_q <= mask_nx;
            if (!fits) ovf_q <= 1'b1;
         end
      end
   end

   sxc_colbank #(.COLS(COLS), .CW(CW), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(bank_clr), .add_en(bank_add),
      .col(col_q), .add_val(bank_inc), .pfx_en(bank_pfx),
      .col_val(bank_val), .total(bank_total)
   );

   sxc_expand #(.RW(RW), .CW(CW), .COORD_W(COORD_W)) u_exp (
      .mask(mask_q), .col(col_q), .row(row_q),
      .xoff(word_q[XO_BIT]), .yoff(word_q[YO_BIT]), .oct(word_q[OCT_LSB +: 8]),
      .has_bit(has_bit), .scale(sc), .mask_nx(mask_nx), .x(xf), .y(yf)
   );

   assign busy       = (st != ST_IDLE);
   assign rd_addr    = ADDR_W'(int'(row_q) * COLS + int'(col_q));
   assign wr_addr    = OUT_AW'(bank_val);
   assign wr_x       = xf;
   assign wr_y       = yf;
   assign wr_scale   = sc;
   assign wr_octave  = word_q[OCT_LSB +: 8];
   assign feat_count = bank_total;
   assign overflow   = ovf_q;

   // R2: every read address falls inside the array
   a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> int'(rd_addr) < ROWS*COLS);

   // R6: back-to-back writes step the record index by one
   a_r6_contig: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + OUT_AW'(1));

   // R7: overflow flag agrees with the total at completion
   a_r7_ovf_match: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (overflow == (int'(feat_count) > CAP)));

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: results do not move while idle
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> ($stable(feat_count) && $stable(overflow)));
endmodule

// File: tb/sim_sxc_compactor.sv
`timescale 1ns/1ps
module sim_sxc_compactor;
   localparam int ROWS = 4, COLS = 4, CAP = 16, COORD_W = 16;
   localparam int W = ROWS * COLS;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic busy, done, rd_en, wr_en, overflow;
   logic [3:0]  rd_addr, wr_addr;
   logic [31:0] rd_data = '0;
   logic [15:0] wr_x, wr_y;
   logic [2:0]  wr_scale;
   logic [7:0]  wr_octave, feat_count;

   always #2.5 clk = ~clk;

   sxc_compactor #(.ROWS(ROWS), .COLS(COLS), .CAP(CAP), .COORD_W(COORD_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_x(wr_x), .wr_y(wr_y),
      .wr_scale(wr_scale), .wr_octave(wr_octave),
      .feat_count(feat_count), .overflow(overflow));

   logic [31:0] mem [W];
   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   logic        cap_clr = 1'b0;
   int          wr_cnt, gap_err;
   logic [15:0] cx [CAP];
   logic [15:0] cy [CAP];
   logic [2:0]  cs [CAP];
   logic [7:0]  co [CAP];
   always @(posedge clk) begin
      if (cap_clr) begin
         wr_cnt <= 0; gap_err <= 0;
      end else if (wr_en) begin
         if (int'(wr_addr) != wr_cnt) gap_err <= gap_err + 1;
         cx[wr_addr] <= wr_x; cy[wr_addr] <= wr_y;
         cs[wr_addr] <= wr_scale; co[wr_addr] <= wr_octave;
         wr_cnt <= wr_cnt + 1;
      end
   end

   int n_tests = 0, n_fail = 0;
   int ex_n;
   logic [15:0] ex_x [CAP];
   logic [15:0] ex_y [CAP];
   logic [2:0]  ex_s [CAP];
   logic [7:0]  ex_o [CAP];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit xo, input bit yo, input logic [7:0] m,
                                      input logic [7:0] oc);
      return {oc, m, 7'd0, yo, 7'd0, xo};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < W; i++) mem[i] = '0;
   endtask

   // Reference list built from R2, R4, R5
   task automatic model();
      ex_n = 0;
      for (int c = 0; c < COLS; c++)
         for (int r = 0; r < ROWS; r++) begin
            logic [31:0] w;
            w = mem[r*COLS + c];
            for (int s = 0; s < 8; s++)
               if (w[16+s]) begin
                  if (ex_n < CAP) begin
                     ex_x[ex_n] = 16'((2*c + int'(w[0])) << w[31:24]);
                     ex_y[ex_n] = 16'((2*r + int'(w[8])) << w[31:24]);
                     ex_s[ex_n] = 3'(s);
                     ex_o[ex_n] = w[31:24];
                  end
                  ex_n++;
               end
         end
   endtask

   task automatic run(input string name, input bit poke_mid);
      int n;
      model();
      @(negedge clk); cap_clr = 1'b1;
      @(negedge clk); cap_clr = 1'b0; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      n = 0;
      while (!done && n < 5000) begin
         @(posedge clk); #1; n++;
         if (poke_mid && n == 20) start = 1'b1;
         if (poke_mid && n == 21) start = 1'b0;
      end
      chk(n == 5*W + ex_n + 1, {name, " R8 done latency"}, n, 5*W + ex_n + 1);
      chk(int'(feat_count) == ex_n, {name, " R3 count"}, feat_count, ex_n);
      chk(overflow == (ex_n > CAP), {name, " R7 overflow"}, overflow, ex_n > CAP);
      @(posedge clk); #1;
      chk(!done, {name, " R8 one-cycle done"}, done, 0);
      chk(wr_cnt == ((ex_n > CAP) ? CAP : ex_n), {name, " R7 writes"}, wr_cnt,
          (ex_n > CAP) ? CAP : ex_n);
      chk(gap_err == 0, {name, " R4 dense index"}, gap_err, 0);
      for (int i = 0; i < CAP && i < ex_n; i++) begin
         chk(cx[i] == ex_x[i], {name, " R5 x"}, cx[i], ex_x[i]);
         chk(cy[i] == ex_y[i], {name, " R5 y"}, cy[i], ex_y[i]);
         chk(cs[i] == ex_s[i], {name, " R4 scale order"}, cs[i], ex_s[i]);
         chk(co[i] == ex_o[i], {name, " R5 octave"}, co[i], ex_o[i]);
      end
      repeat (5) @(posedge clk); #1;
      chk(int'(feat_count) == ex_n && !busy, {name, " R9 hold"}, feat_count, ex_n);
   endtask

   task automatic t_reset();
      #1;
      chk(!busy && !done && !rd_en && !wr_en && !overflow && feat_count == 0,
          "R1 reset state", {busy, done, rd_en, wr_en, overflow}, 0);
   endtask

   task automatic t_single();
      clear_mem();
      mem[2*COLS + 1] = mk(1'b1, 1'b1, 8'b0000_0010, 8'd1);
      run("single R2", 1'b0);
      chk(cx[0] == 16'd6 && cy[0] == 16'd10, "R5 literal coords", cx[0], 6);
      chk(cs[0] == 3'd1, "R2 mask bit to scale", cs[0], 1);
   endtask

   task automatic t_multi();
      clear_mem();
      mem[0*COLS + 0] = mk(1'b1, 1'b0, 8'b0000_0101, 8'd0);
      mem[2*COLS + 0] = mk(1'b0, 1'b1, 8'b1000_0000, 8'd2);
      mem[1*COLS + 3] = mk(1'b1, 1'b1, 8'b0000_1010, 8'd1);
      mem[3*COLS + 1] = mk(1'b0, 1'b0, 8'b0000_0001, 8'd3);
      run("multi R6", 1'b0);
      chk(cs[0] == 3'd0 && cs[1] == 3'd2, "R4 ascending scales", cs[1], 2);
   endtask

   task automatic t_empty();
      clear_mem();
      run("empty R10", 1'b0);
      chk(wr_cnt == 0, "R10 no writes", wr_cnt, 0);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < W; i++) mem[i] = mk(i[0], i[1], 8'hFF, 8'd0);
      run("full R7", 1'b0);
      chk(feat_count == 8'd128 && overflow, "R7 true total kept", feat_count, 128);
   endtask

   task automatic t_restart();
      clear_mem();
      mem[1*COLS + 2] = mk(1'b0, 1'b1, 8'b0011_0000, 8'd2);
      mem[0*COLS + 3] = mk(1'b1, 1'b0, 8'b0000_0001, 8'd0);
      run("restart R9", 1'b1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      clear_mem();
      cap_clr = 1'b1;
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk); rst_n = 1'b1; cap_clr = 1'b0;
      @(posedge clk); t_reset();
      t_single();
      t_multi();
      t_empty();
      t_overflow();
      t_restart();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule